// File: doc/BRIEF.md
# Timer and External Interrupt Control/Status Register

This block is one byte-wide special-function register of a small microcontroller core. It holds the run enables for two timer counters and the overflow flags those timers raise. It also captures two active-low external interrupt pins, each in either edge mode or level mode. The CPU reads and writes the register through a simple register port. The timer counters pulse an overflow input for one cycle. The interrupt sequencer pulses a per-source acknowledge strobe when it vectors to a handler, and that strobe clears the matching flag.

Each external pin passes through a two-flop synchronizer. A two-state tracker then watches the synchronized sample. `ST_HI` means the pin was last seen high. `ST_LO` means it was last seen low. The transition `ST_HI -> ST_LO` is a falling edge and emits a one-cycle edge event. The transition `ST_LO -> ST_HI` is a rising edge and has no effect. In edge mode the event sets a stored flag. In level mode the flag is not stored at all: it shows the inverted synchronized pin.

Top module: `tmr_irq_ctl`

## Requirements
- R1: The register answers only at address `ADDR` (default 8'h88). A read there returns the register. A read at any other address returns 8'h00. A write to any other address changes nothing. The bit layout, from bit 7 down to bit 0, is:
  - bit 7: timer 1 flag
  - bit 6: timer 1 run
  - bit 5: timer 0 flag
  - bit 4: timer 0 run
  - bit 3: external 1 flag
  - bit 2: external 1 mode
  - bit 1: external 0 flag
  - bit 0: external 0 mode
- R2: After reset, with both pins high, every field is 0 and a read returns 8'h00.
- R3: The run bits (bit 6 for timer 1, bit 4 for timer 0) take the written value and drive `tmr_run`. They keep that value until the next write.
- R4: A one-cycle `tmr_ovf[i]` pulse sets timer flag i (bit 7 for i=1, bit 5 for i=0) on the same clock edge. The flag is visible on `tmr_irq[i]` right after that edge.
- R5: A timer flag is cleared by writing 0 to it or by `tmr_ack[i]`. Writing 1 sets it.
- R6: When an overflow coincides with a software write of 0, or with an acknowledge, to the same timer flag, the flag ends up set.
- R7: In edge mode (mode bit = 1), a falling edge of the pin sets the external flag. The flag is visible after the third rising clock edge after the pin falls. It stays set until software writes 0 to it or `ext_ack[i]` is pulsed. A rising pin edge sets nothing.
- R8: In edge mode, when an edge event coincides with an acknowledge or a software write of 0 to the same flag, the flag ends up set.
- R9: In level mode (mode bit = 0), the external flag bit and `ext_irq[i]` equal the inverse of the pin as sampled two rising edges earlier. Software writes to the flag bit and `ext_ack[i]` have no effect on it.
- R10: While a channel is in level mode its stored edge flag is held clear. A switch to edge mode therefore starts with the flag at 0 until a new falling edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wr | input | 1 | Write strobe, one cycle per write |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, combinational from address |
| tmr_ovf | input | 2 | Overflow pulses from timer 1 and timer 0 |
| tmr_ack | input | 2 | Vector acknowledge for each timer interrupt |
| ext_pin_n | input | 2 | Asynchronous active-low external interrupt pins |
| ext_ack | input | 2 | Vector acknowledge for each external interrupt |
| tmr_run | output | 2 | Timer run enables |
| tmr_irq | output | 2 | Timer overflow interrupt requests |
| ext_irq | output | 2 | External interrupt requests |

## Verification
The hardest case to reach from the ports is an external edge event that lands in exactly the same cycle as an acknowledge or a software clear. The event appears three clock edges after the pin moves, and nothing visible marks that cycle. The stimulus therefore lowers a pin and then sweeps the acknowledge, and separately a write of 0, across delays of zero to five cycles. One of the delays always hits the event cycle. The behavioural model, compared on every clock, then shows whether the set won. A random phase adds coincidences of overflows, mode changes and pin toggles.

// File: rtl/tmr_irq_pkg.sv
`timescale 1ns/1ps
package tmr_irq_pkg;
    // Number of timers and of external interrupt channels.
    localparam int unsigned CHANS = 2;

    // Bit positions for channel 0. Channel 1 sits two bits higher.
    localparam int unsigned MODE_LSB = 0;
    localparam int unsigned EXTF_LSB = 1;
    localparam int unsigned RUN_LSB  = 4;
    localparam int unsigned TMRF_LSB = 5;
    localparam int unsigned STRIDE   = 2;

    // Edge tracker states: the last synchronized sample was high or low.
    typedef enum logic {
        ST_HI = 1'b0,
        ST_LO = 1'b1
    } pin_state_e;
endpackage

// File: rtl/tic_tmr_flag.sv
`timescale 1ns/1ps
module tic_tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_run,
    input  logic wr_flag,
    input  logic ovf,
    input  logic ack,
    output logic run_o,
    output logic flag_o
);
    logic run_q;
    logic flag_q;

    // Run enable: software owned.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (wr_en) begin
            run_q <= wr_run;
        end
    end

    // Overflow flag priority: hardware set, then acknowledge, then software.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ovf) begin
            flag_q <= 1'b1;
        end else if (ack) begin
            flag_q <= 1'b0;
        end else if (wr_en) begin
            flag_q <= wr_flag;
        end
    end

    assign run_o  = run_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/tic_ext_chan.sv
`timescale 1ns/1ps
module tic_ext_chan
    import tmr_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic wr_en,
    input  logic wr_mode,
    input  logic wr_flag,
    input  logic ack,
    output logic mode_o,
    output logic flag_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   smp;
    pin_state_e             state_q;
    pin_state_e             state_d;
    logic                   fall;
    logic                   mode_q;
    logic                   latch_q;

    // Synchronizer. It resets to the idle-high level so no false edge appears.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
        end
    end
    assign smp = sync_q[SYNC_STAGES-1];

    // Edge tracker: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HI;
        end else begin
            state_q <= state_d;
        end
    end

    // Edge tracker: next state and the falling-edge event.
    always_comb begin
        state_d = state_q;
        fall    = 1'b0;
        unique case (state_q)
            ST_HI: begin
                if (!smp) begin
                    state_d = ST_LO;
                    fall    = 1'b1;
                end
            end
            ST_LO: begin
                if (smp) begin
                    state_d = ST_HI;
                end
            end
        endcase
    end

    // Mode select bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (wr_en) begin
            mode_q <= wr_mode;
        end
    end

    // Stored edge flag. It is held clear while the channel is in level mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else if (!mode_q) begin
            latch_q <= 1'b0;
        end else if (fall) begin
            latch_q <= 1'b1;
        end else if (ack) begin
            latch_q <= 1'b0;
        end else if (wr_en) begin
            latch_q <= wr_flag;
        end
    end

    assign mode_o = mode_q;
    assign flag_o = mode_q ? latch_q : ~smp;
endmodule

// File: rtl/tmr_irq_ctl.sv
`timescale 1ns/1ps
module tmr_irq_ctl
    import tmr_irq_pkg::*;
#(
    parameter logic [7:0]  ADDR        = 8'h88,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_wr,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    input  logic [1:0] tmr_ovf,
    input  logic [1:0] tmr_ack,
    input  logic [1:0] ext_pin_n,
    input  logic [1:0] ext_ack,
    output logic [1:0] tmr_run,
    output logic [1:0] tmr_irq,
    output logic [1:0] ext_irq
);
    logic       wr_hit;
    logic [7:0] regval;
    logic [1:0] ext_mode;

    assign wr_hit = sfr_wr && (sfr_addr == ADDR);

    for (genvar i = 0; i < CHANS; i++) begin : g_ch
        tic_tmr_flag u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wr_run  (sfr_wdata[RUN_LSB + STRIDE*i]),
            .wr_flag (sfr_wdata[TMRF_LSB + STRIDE*i]),
            .ovf     (tmr_ovf[i]),
            .ack     (tmr_ack[i]),
            .run_o   (tmr_run[i]),
            .flag_o  (tmr_irq[i])
        );

        tic_ext_chan #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_n   (ext_pin_n[i]),
            .wr_en   (wr_hit),
            .wr_mode (sfr_wdata[MODE_LSB + STRIDE*i]),
            .wr_flag (sfr_wdata[EXTF_LSB + STRIDE*i]),
            .ack     (ext_ack[i]),
            .mode_o  (ext_mode[i]),
            .flag_o  (ext_irq[i])
        );

        assign regval[RUN_LSB  + STRIDE*i] = tmr_run[i];
        assign regval[TMRF_LSB + STRIDE*i] = tmr_irq[i];
        assign regval[MODE_LSB + STRIDE*i] = ext_mode[i];
        assign regval[EXTF_LSB + STRIDE*i] = ext_irq[i];
    end

    assign sfr_rdata = (sfr_addr == ADDR) ? regval : 8'h00;
endmodule

// File: rtl/tic_chk.sv
`timescale 1ns/1ps
module tic_chk #(
    parameter logic [7:0] ADDR = 8'h88
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] sfr_addr,
    input logic       sfr_wr,
    input logic [7:0] sfr_wdata,
    input logic [1:0] tmr_ovf,
    input logic [1:0] tmr_ack,
    input logic [1:0] ext_pin_n,
    input logic [1:0] ext_ack,
    input logic [1:0] tmr_run,
    input logic [1:0] tmr_irq,
    input logic [1:0] ext_irq,
    input logic [1:0] ext_mode
);
    logic [1:0] since_rst;
    logic       hit;

    assign hit = sfr_wr && (sfr_addr == ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_a
        assert_ovf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_ovf[i] |=> tmr_irq[i]);

        assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_ack[i] && !tmr_ovf[i]) |=> !tmr_irq[i]);

        assert_run_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (tmr_run[i] == $past(sfr_wdata[4 + 2*i])));

        assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !hit |=> $stable(tmr_run[i]));

        assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_mode[i] && ext_irq[i] && !ext_ack[i] && !hit) |=> ext_irq[i]);

        assert_level_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ext_mode[i] && since_rst >= 2'd2) |-> (ext_irq[i] == !$past(ext_pin_n[i], 2)));
    end
endmodule

bind tmr_irq_ctl tic_chk #(.ADDR(ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .tmr_ovf   (tmr_ovf),
    .tmr_ack   (tmr_ack),
    .ext_pin_n (ext_pin_n),
    .ext_ack   (ext_ack),
    .tmr_run   (tmr_run),
    .tmr_irq   (tmr_irq),
    .ext_irq   (ext_irq),
    .ext_mode  (ext_mode)
);

// File: tb/tb_tmr_irq_ctl.sv
`timescale 1ns/1ps
module tb_tmr_irq_ctl;
    localparam logic [7:0] ADDR = 8'h88;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] sfr_addr;
    logic       sfr_wr;
    logic [7:0] sfr_wdata;
    wire  [7:0] sfr_rdata;
    logic [1:0] tmr_ovf, tmr_ack, ext_pin_n, ext_ack;
    wire  [1:0] tmr_run, tmr_irq, ext_irq;

    always #4 clk = ~clk;   // 125 MHz

    tmr_irq_ctl #(.ADDR(ADDR)) dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .tmr_ovf(tmr_ovf),
        .tmr_ack(tmr_ack), .ext_pin_n(ext_pin_n), .ext_ack(ext_ack),
        .tmr_run(tmr_run), .tmr_irq(tmr_irq), .ext_irq(ext_irq)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R2";
    bit    cmp_on  = 1'b0;
    bit    done    = 1'b0;

    // Reference model: fields kept by requirement, pin history in a queue.
    bit [1:0]   m_run, m_tf, m_mode, m_lat;
    logic [1:0] pinq[$];
    logic [1:0] s_now, s_old;
    bit         hit, ed;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_tf = 0; m_mode = 0; m_lat = 0;
            pinq = '{2'b11, 2'b11, 2'b11};
        end else begin
            s_now = pinq[1];
            s_old = pinq[2];
            hit = sfr_wr && (sfr_addr == ADDR);
            for (int i = 0; i < 2; i++) begin
                ed = s_old[i] && !s_now[i];
                if (!m_mode[i])      m_lat[i] = 1'b0;          // R10
                else if (ed)         m_lat[i] = 1'b1;          // R7, R8
                else if (ext_ack[i]) m_lat[i] = 1'b0;
                else if (hit)        m_lat[i] = sfr_wdata[1 + 2*i];
                if (tmr_ovf[i])      m_tf[i] = 1'b1;           // R4, R6
                else if (tmr_ack[i]) m_tf[i] = 1'b0;           // R5
                else if (hit)        m_tf[i] = sfr_wdata[5 + 2*i];
                if (hit) begin
                    m_run[i]  = sfr_wdata[4 + 2*i];            // R3
                    m_mode[i] = sfr_wdata[2*i];
                end
            end
            pinq.push_front(ext_pin_n);
            void'(pinq.pop_back());
        end
    end

    function automatic logic [1:0] exp_ext();
        logic [1:0] r;
        for (int i = 0; i < 2; i++) r[i] = m_mode[i] ? m_lat[i] : !pinq[1][i];   // R9
        return r;
    endfunction

    function automatic logic [7:0] exp_rd();
        logic [1:0] e;
        e = exp_ext();
        if (sfr_addr != ADDR) return 8'h00;                                        // R1
        return {m_tf[1], m_run[1], m_tf[0], m_run[0], e[1], m_mode[1], e[0], m_mode[0]};
    endfunction

    task automatic check(string what, logic [7:0] got, logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("rdata", sfr_rdata, exp_rd());
            check("tmr_run", {6'd0, tmr_run}, {6'd0, m_run});
            check("tmr_irq", {6'd0, tmr_irq}, {6'd0, m_tf});
            check("ext_irq", {6'd0, ext_irq}, {6'd0, exp_ext()});
        end
    end

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        cyc(1);
        sfr_wr = 1'b0; sfr_addr = ADDR;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; sfr_addr = ADDR; sfr_wr = 1'b0; sfr_wdata = 8'h00;
        tmr_ovf = 0; tmr_ack = 0; ext_ack = 0; ext_pin_n = 2'b11;
        @(posedge clk); #2;
        cmp_on = 1'b1;                       // R2: reset values compared from here
        cyc(2);
        rst_n = 1'b1;
        cyc(2);

        cur_req = "R1";
        wr(8'h89, 8'hFF); cyc(1);
        sfr_addr = 8'h89; cyc(2); sfr_addr = 8'h08; cyc(1); sfr_addr = ADDR; cyc(1);

        cur_req = "R3";
        wr(ADDR, 8'h10); cyc(2); wr(ADDR, 8'h40); cyc(2); wr(ADDR, 8'h50); cyc(2);
        wr(ADDR, 8'h00); cyc(1);

        cur_req = "R4";
        tmr_ovf = 2'b01; cyc(1); tmr_ovf = 0; cyc(2);
        tmr_ovf = 2'b10; cyc(1); tmr_ovf = 0; cyc(2);

        cur_req = "R5";
        wr(ADDR, 8'h00); cyc(2);
        tmr_ovf = 2'b11; cyc(1); tmr_ovf = 0; cyc(1);
        tmr_ack = 2'b01; cyc(1); tmr_ack = 2'b10; cyc(1); tmr_ack = 0; cyc(1);
        wr(ADDR, 8'hA0); cyc(2); wr(ADDR, 8'h00); cyc(1);

        cur_req = "R6";
        tmr_ovf = 2'b11; sfr_wdata = 8'h00; sfr_wr = 1'b1; cyc(1); sfr_wr = 0; tmr_ovf = 0; cyc(2);
        tmr_ovf = 2'b11; tmr_ack = 2'b11; cyc(1); tmr_ovf = 0; tmr_ack = 0; cyc(2);
        wr(ADDR, 8'h00); cyc(1);

        cur_req = "R9";
        ext_pin_n = 2'b10; cyc(4);
        wr(ADDR, 8'h0A); cyc(1); wr(ADDR, 8'h00); cyc(1);
        ext_ack = 2'b11; cyc(1); ext_ack = 0;
        ext_pin_n = 2'b01; cyc(4); ext_pin_n = 2'b11; cyc(4);

        cur_req = "R7";
        wr(ADDR, 8'h05); cyc(2);
        ext_pin_n = 2'b10; cyc(6); ext_pin_n = 2'b11; cyc(5);
        wr(ADDR, 8'h05); cyc(2);
        ext_pin_n = 2'b01; cyc(6); ext_ack = 2'b10; cyc(1); ext_ack = 0; cyc(1);
        ext_pin_n = 2'b11; cyc(5);

        cur_req = "R8";
        for (int d = 0; d < 6; d++) begin
            ext_pin_n = 2'b00; cyc(d);
            ext_ack = 2'b11; cyc(1); ext_ack = 0; cyc(4);
            ext_pin_n = 2'b11; cyc(4);
            ext_pin_n = 2'b00; cyc(d);
            wr(ADDR, 8'h05); cyc(4);
            ext_pin_n = 2'b11; cyc(4);
            wr(ADDR, 8'h05); cyc(1);
        end

        cur_req = "R10";
        wr(ADDR, 8'h00); ext_pin_n = 2'b00; cyc(5);
        wr(ADDR, 8'h05); cyc(4); ext_pin_n = 2'b11; cyc(4);

        cur_req = "R7 mixed";
        for (int k = 0; k < 4000; k++) begin
            tmr_ovf = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            tmr_ack = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            ext_ack = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
            if (($urandom % 5) == 0) ext_pin_n = 2'($urandom);
            sfr_wr = (($urandom % 10) == 0);
            sfr_wdata = 8'($urandom);
            sfr_addr = (($urandom % 4) == 0) ? 8'($urandom) : ADDR;
            cyc(1);
        end
        tmr_ovf = 0; tmr_ack = 0; ext_ack = 0; sfr_wr = 0; sfr_addr = ADDR;
        cyc(3);
        finish_run();
    end
endmodule